// File: doc/BRIEF.md
# Programmable Closed-Loop Phase Offset

This block supplies the phase offset, in picoseconds, that a digital PLL's phase detector places between reference and feedback edges. Software sets a signed fixed offset and an unsigned step size through a byte-wide register port. The offset also has an incremental part that moves by one step each time an up, down or zero command arrives. These commands come either from self-clearing bits in a command register or from three external control pins.

The fixed offset and the incremental accumulator are held apart. A change to one never disturbs the other. The output is their sum, one bit wider than the fixed offset. The accumulator clips at its signed limits and does not wrap, so a long run of steps in one direction cannot flip the sign of the offset.

Top module: `phase_offset_ctrl`

## Requirements
- R1: After synchronous reset the fixed offset, the step size and the accumulator are all zero, and every register reads back as 0x00.
- R2: Byte addresses 0 to 4 hold the 40-bit two's-complement fixed offset, with address 0 as bits 7:0 and address 4 as bits 39:32. Addresses 5 and 6 hold the 16-bit unsigned step size, with address 5 as the low byte. Each of these reads back the value last written to it.
- R3: Address 7 is the command register: bit 0 steps up, bit 1 steps down, bit 2 zeroes the accumulator. A command acts once, and the register always reads 0x00.
- R4: A step-up command adds the step size to the accumulator once. The result is visible on the second rising clock edge after the write.
- R5: A step-down command subtracts the step size from the accumulator once, with the same timing as R4.
- R6: A zero command sets the accumulator to 0. It wins over a step-up or step-down command present in the same cycle.
- R7: Step-up and step-down together in one cycle, with no zero command, leave the accumulator unchanged. With no command at all the accumulator also holds.
- R8: The pins pin_inc, pin_dec and pin_clr are synchronized through two flops and act on their rising edge only. One pulse, however long, gives exactly one command, in the same way as the matching command bit.
- R9: The accumulator saturates at +(2^(INC_W-1))-1 and at -(2^(INC_W-1)) instead of wrapping.
- R10: total_ofs equals the fixed offset plus the sign-extended accumulator, as a 41-bit signed value. Writing the fixed offset leaves the accumulator unchanged, and commands leave the fixed offset unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W (3) | Byte address for write and read |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| pin_inc | input | 1 | Asynchronous step-up pin |
| pin_dec | input | 1 | Asynchronous step-down pin |
| pin_clr | input | 1 | Asynchronous zero pin |
| inc_ofs | output | INC_W (40) | Incremental accumulator, signed ps |
| total_ofs | output | FIX_W+1 (41) | Fixed plus incremental offset, signed ps |

## Verification
The stepping function is driven in four ways. Single up or down writes confirm the sign and the one-shot action. Combined command bytes (up+down, zero+up) separate cancellation from zero priority. Long and repeated pin pulses separate edge detection from level sensing. Runs of full-scale steps against a narrowed accumulator land exactly on each limit, so clipping shows apart from wrapping. A negative fixed offset, rewritten while the accumulator is non-zero, shows that the two parts are summed with correct sign extension and are stored independently.

// File: rtl/phofs_pkg.sv
package phofs_pkg;

    typedef struct packed {
        logic clr;
        logic dec;
        logic inc;
    } step_cmd_t;

    localparam int CMD_INC_BIT = 0;
    localparam int CMD_DEC_BIT = 1;
    localparam int CMD_CLR_BIT = 2;

    typedef enum logic [1:0] {
        ACT_HOLD,
        ACT_UP,
        ACT_DOWN,
        ACT_ZERO
    } acc_act_t;

    function automatic step_cmd_t merge_cmd(input step_cmd_t a, input step_cmd_t b);
        step_cmd_t r;
        r.inc = a.inc | b.inc;
        r.dec = a.dec | b.dec;
        r.clr = a.clr | b.clr;
        return r;
    endfunction

    function automatic acc_act_t resolve_act(input step_cmd_t c);
        if (c.clr)
            return ACT_ZERO;
        else if (c.inc && !c.dec)
            return ACT_UP;
        else if (c.dec && !c.inc)
            return ACT_DOWN;
        else
            return ACT_HOLD;
    endfunction

endpackage

// File: rtl/phofs_regs.sv
module phofs_regs
    import phofs_pkg::*;
#(
    parameter int FIX_W  = 40,
    parameter int STEP_W = 16,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic [FIX_W-1:0]  fix_val,
    output logic [STEP_W-1:0] step_val,
    output step_cmd_t         cmd_strobe
);

    localparam int FIX_BYTES  = (FIX_W + 7) / 8;
    localparam int STEP_BYTES = (STEP_W + 7) / 8;
    localparam int STEP_BASE  = FIX_BYTES;
    localparam int CMD_ADDR   = FIX_BYTES + STEP_BYTES;
    localparam int NREG       = CMD_ADDR;

    logic [7:0] bank [NREG];
    logic [FIX_BYTES*8-1:0]  fix_wide;
    logic [STEP_BYTES*8-1:0] step_wide;

    for (genvar g = 0; g < NREG; g++) begin : g_byte
        always_ff @(posedge clk) begin
            if (rst)
                bank[g] <= 8'h00;
            else if (reg_we && (int'(reg_addr) == g))
                bank[g] <= reg_wdata;
        end
    end

    always_comb begin
        for (int i = 0; i < FIX_BYTES; i++)
            fix_wide[i*8 +: 8] = bank[i];
        for (int i = 0; i < STEP_BYTES; i++)
            step_wide[i*8 +: 8] = bank[STEP_BASE + i];
    end

    assign fix_val  = fix_wide[FIX_W-1:0];
    assign step_val = step_wide[STEP_W-1:0];

    always_comb begin
        reg_rdata = 8'h00;
        for (int i = 0; i < NREG; i++)
            if (int'(reg_addr) == i)
                reg_rdata = bank[i];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_strobe <= '0;
        end else if (reg_we && (int'(reg_addr) == CMD_ADDR)) begin
            cmd_strobe.inc <= reg_wdata[CMD_INC_BIT];
            cmd_strobe.dec <= reg_wdata[CMD_DEC_BIT];
            cmd_strobe.clr <= reg_wdata[CMD_CLR_BIT];
        end else begin
            cmd_strobe <= '0;
        end
    end

endmodule

// File: rtl/phofs_pin_sync.sv
module phofs_pin_sync #(
    parameter int N_PINS = 3,
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_PINS-1:0] pin_async,
    output logic [N_PINS-1:0] pin_rise
);

    for (genvar p = 0; p < N_PINS; p++) begin : g_pin
        logic [STAGES-1:0] chain;
        logic              last;

        always_ff @(posedge clk) begin
            if (rst) begin
                chain <= '0;
                last  <= 1'b0;
            end else begin
                chain <= {chain[STAGES-2:0], pin_async[p]};
                last  <= chain[STAGES-1];
            end
        end

        assign pin_rise[p] = chain[STAGES-1] & ~last;
    end

endmodule

// File: rtl/phofs_accum.sv
module phofs_accum
    import phofs_pkg::*;
#(
    parameter int INC_W  = 40,
    parameter int STEP_W = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  step_cmd_t               cmd,
    input  logic [STEP_W-1:0]       step,
    output logic signed [INC_W-1:0] acc
);

    localparam logic signed [INC_W-1:0] ACC_MAX = {1'b0, {(INC_W-1){1'b1}}};
    localparam logic signed [INC_W-1:0] ACC_MIN = {1'b1, {(INC_W-1){1'b0}}};

    acc_act_t           act;
    logic [INC_W:0]     step_x;
    logic [INC_W:0]     acc_x;
    logic [INC_W:0]     sum_up;
    logic [INC_W:0]     sum_dn;
    logic signed [INC_W-1:0] nxt_up;
    logic signed [INC_W-1:0] nxt_dn;

    assign act    = resolve_act(cmd);
    assign step_x = {{(INC_W+1-STEP_W){1'b0}}, step};
    assign acc_x  = {acc[INC_W-1], acc};
    assign sum_up = acc_x + step_x;
    assign sum_dn = acc_x - step_x;

    always_comb begin
        if (sum_up[INC_W] != sum_up[INC_W-1])
            nxt_up = ACC_MAX;
        else
            nxt_up = sum_up[INC_W-1:0];
        if (sum_dn[INC_W] != sum_dn[INC_W-1])
            nxt_dn = ACC_MIN;
        else
            nxt_dn = sum_dn[INC_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc <= '0;
        end else begin
            unique case (act)
                ACT_UP:   acc <= nxt_up;
                ACT_DOWN: acc <= nxt_dn;
                ACT_ZERO: acc <= '0;
                default:  acc <= acc;
            endcase
        end
    end

endmodule

// File: rtl/phase_offset_ctrl.sv
module phase_offset_ctrl
    import phofs_pkg::*;
#(
    parameter int FIX_W  = 40,
    parameter int STEP_W = 16,
    parameter int INC_W  = 40,
    parameter int ADDR_W = 3
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    reg_we,
    input  logic [ADDR_W-1:0]       reg_addr,
    input  logic [7:0]              reg_wdata,
    output logic [7:0]              reg_rdata,
    input  logic                    pin_inc,
    input  logic                    pin_dec,
    input  logic                    pin_clr,
    output logic signed [INC_W-1:0] inc_ofs,
    output logic signed [FIX_W:0]   total_ofs
);

    localparam int SUM_W = FIX_W + 1;

    logic [FIX_W-1:0]  fix_val;
    logic [STEP_W-1:0] step_val;
    step_cmd_t         reg_cmd;
    step_cmd_t         pin_cmd;
    step_cmd_t         cmd_all;
    logic [2:0]        pin_rise;

    phofs_regs #(
        .FIX_W (FIX_W),
        .STEP_W(STEP_W),
        .ADDR_W(ADDR_W)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .fix_val   (fix_val),
        .step_val  (step_val),
        .cmd_strobe(reg_cmd)
    );

    phofs_pin_sync #(
        .N_PINS(3),
        .STAGES(2)
    ) u_sync (
        .clk      (clk),
        .rst      (rst),
        .pin_async({pin_clr, pin_dec, pin_inc}),
        .pin_rise (pin_rise)
    );

    assign pin_cmd.inc = pin_rise[0];
    assign pin_cmd.dec = pin_rise[1];
    assign pin_cmd.clr = pin_rise[2];
    assign cmd_all     = merge_cmd(reg_cmd, pin_cmd);

    phofs_accum #(
        .INC_W (INC_W),
        .STEP_W(STEP_W)
    ) u_acc (
        .clk (clk),
        .rst (rst),
        .cmd (cmd_all),
        .step(step_val),
        .acc (inc_ofs)
    );

    logic signed [SUM_W-1:0] fix_ext;
    logic signed [SUM_W-1:0] inc_ext;

    assign fix_ext   = {fix_val[FIX_W-1], fix_val};
    assign inc_ext   = {{(SUM_W-INC_W){inc_ofs[INC_W-1]}}, inc_ofs};
    assign total_ofs = fix_ext + inc_ext;

endmodule

// File: rtl/phofs_chk.sv
module phofs_chk #(
    parameter int FIX_W = 40,
    parameter int INC_W = 40
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    reg_we,
    input logic                    c_inc,
    input logic                    c_dec,
    input logic                    c_clr,
    input logic [FIX_W-1:0]        fix_val,
    input logic signed [INC_W-1:0] inc_ofs,
    input logic signed [FIX_W:0]   total_ofs
);

    // R1: first cycle out of reset starts from zero
    a_r1_reset_zero: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (inc_ofs == '0));

    // R6: zero command clears accumulator regardless of others
    a_r6_clear_wins: assert property (@(posedge clk) disable iff (rst)
        c_clr |=> (inc_ofs == '0));

    // R7: opposing commands cancel
    a_r7_cancel_hold: assert property (@(posedge clk) disable iff (rst)
        (c_inc && c_dec && !c_clr) |=> $stable(inc_ofs));

    // R7: no command, no movement
    a_r7_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!c_inc && !c_dec && !c_clr) |=> $stable(inc_ofs));

    // R9: stepping up never lowers the value (no wrap)
    a_r9_up_no_wrap: assert property (@(posedge clk) disable iff (rst)
        (c_inc && !c_dec && !c_clr) |=> (inc_ofs >= $past(inc_ofs)));

    // R9: stepping down never raises the value (no wrap)
    a_r9_down_no_wrap: assert property (@(posedge clk) disable iff (rst)
        (c_dec && !c_inc && !c_clr) |=> (inc_ofs <= $past(inc_ofs)));

    // R10: fixed part only moves on a register write
    a_r10_fixed_held: assert property (@(posedge clk) disable iff (rst)
        !reg_we |=> $stable(fix_val));

endmodule

bind phase_offset_ctrl phofs_chk #(
    .FIX_W(FIX_W),
    .INC_W(INC_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .reg_we   (reg_we),
    .c_inc    (cmd_all.inc),
    .c_dec    (cmd_all.dec),
    .c_clr    (cmd_all.clr),
    .fix_val  (fix_val),
    .inc_ofs  (inc_ofs),
    .total_ofs(total_ofs)
);

// File: tb/sim_phase_offset_ctrl.sv
`timescale 1ns/1ps
module sim_phase_offset_ctrl;

    localparam int FIX_W  = 40;
    localparam int STEP_W = 16;
    localparam int INC_W  = 20;
    localparam int ADDR_W = 3;
    localparam longint ACC_MAX = (64'sd1 <<< (INC_W-1)) - 1;
    localparam longint ACC_MIN = -(64'sd1 <<< (INC_W-1));

    logic                    clk = 1'b0;
    logic                    rst = 1'b1;
    logic                    reg_we = 1'b0;
    logic [ADDR_W-1:0]       reg_addr = '0;
    logic [7:0]              reg_wdata = '0;
    logic [7:0]              reg_rdata;
    logic                    pin_inc = 1'b0;
    logic                    pin_dec = 1'b0;
    logic                    pin_clr = 1'b0;
    logic signed [INC_W-1:0] inc_ofs;
    logic signed [FIX_W:0]   total_ofs;

    int n_checks = 0;
    int n_fail   = 0;
    longint e_fix  = 0;
    longint e_step = 0;
    longint e_acc  = 0;

    always #5 clk = ~clk;

    phase_offset_ctrl #(
        .FIX_W(FIX_W), .STEP_W(STEP_W), .INC_W(INC_W), .ADDR_W(ADDR_W)
    ) u0 (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .pin_inc(pin_inc), .pin_dec(pin_dec), .pin_clr(pin_clr),
        .inc_ofs(inc_ofs), .total_ofs(total_ofs)
    );

    task automatic check(input string req, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a[ADDR_W-1:0]; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input int a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a[ADDR_W-1:0];
        #1 d = reg_rdata;
    endtask

    task automatic settle();
        repeat (2) @(negedge clk);
    endtask

    function automatic longint sat(input longint v);
        if (v > ACC_MAX) return ACC_MAX;
        if (v < ACC_MIN) return ACC_MIN;
        return v;
    endfunction

    task automatic check_out(input string req);
        check(req, longint'(inc_ofs), e_acc);
        check(req, longint'(total_ofs), e_fix + e_acc);
    endtask

    task automatic set_fix(input longint v);
        logic [FIX_W-1:0] b = v[FIX_W-1:0];
        for (int i = 0; i < 5; i++) wr(i, b[i*8 +: 8]);
        e_fix = v;
    endtask

    task automatic set_step(input longint v);
        wr(5, v[7:0]); wr(6, v[15:8]);
        e_step = v;
    endtask

    task automatic cmd(input logic [7:0] c);
        wr(7, c);
        settle();
    endtask

    task automatic t_reset();
        logic [7:0] d;
        check_out("R1");
        for (int i = 0; i < 8; i++) begin
            rd(i, d);
            check("R1", d, 0);
        end
    endtask

    task automatic t_regs();
        logic [7:0] d;
        set_fix(-1000);
        set_step(300);
        settle();
        rd(0, d); check("R2", d, 8'h18);
        rd(1, d); check("R2", d, 8'hFC);
        rd(4, d); check("R2", d, 8'hFF);
        rd(5, d); check("R2", d, 8'h2C);
        rd(6, d); check("R2", d, 8'h01);
        check_out("R10");
    endtask

    task automatic t_step();
        logic [7:0] d;
        cmd(8'h01); e_acc = 300;  check_out("R4");
        rd(7, d); check("R3", d, 0);
        cmd(8'h01); e_acc = 600;  check_out("R4");
        cmd(8'h02); e_acc = 300;  check_out("R5");
        cmd(8'h02); cmd(8'h02); e_acc = -300; check_out("R5");
        cmd(8'h03); check_out("R7");
        cmd(8'h00); check_out("R7");
        cmd(8'h05); e_acc = 0;    check_out("R6");
        cmd(8'h01); cmd(8'h06); e_acc = 0; check_out("R6");
    endtask

    task automatic t_pins();
        pin_inc = 1'b1; repeat (6) @(negedge clk); pin_inc = 1'b0;
        settle(); settle();
        e_acc = 300; check_out("R8");
        for (int k = 0; k < 2; k++) begin
            pin_dec = 1'b1; repeat (2) @(negedge clk); pin_dec = 1'b0;
            repeat (4) @(negedge clk);
        end
        e_acc = -300; check_out("R8");
        pin_clr = 1'b1; repeat (3) @(negedge clk); pin_clr = 1'b0;
        repeat (4) @(negedge clk);
        e_acc = 0; check_out("R8");
    endtask

    task automatic t_sat();
        set_step(16'hFFFF);
        for (int k = 0; k < 8; k++) begin
            cmd(8'h01); e_acc = sat(e_acc + e_step);
        end
        check("R9", longint'(inc_ofs), 8 * 65535);
        cmd(8'h01); e_acc = ACC_MAX; check_out("R9");
        cmd(8'h01); check_out("R9");
        cmd(8'h04); e_acc = 0;
        for (int k = 0; k < 9; k++) begin
            cmd(8'h02); e_acc = sat(e_acc - e_step);
        end
        check("R9", longint'(inc_ofs), ACC_MIN);
        check_out("R9");
    endtask

    task automatic t_indep();
        logic [7:0] d;
        cmd(8'h04); e_acc = 0;
        set_step(77);
        cmd(8'h01); e_acc = 77;
        set_fix(40'sd123456789);
        settle();
        check_out("R10");
        cmd(8'h02); cmd(8'h02); e_acc = -77;
        rd(0, d); check("R10", d, 8'h15);
        rd(3, d); check("R10", d, 8'h07);
        check_out("R10");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_regs();
        t_step();
        t_pins();
        t_sat();
        t_indep();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #1000000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule